// File: doc/BRIEF.md
# Reset Cause and Soft-Reset Control Register

This block keeps a 32-bit status word that tells software why the system last came out of reset, and lets software ask for a new reset. Five flag bits at the top of the word record the cause. One bit marks a power-up reset. Two bits mark a cold or warm reset that a front-panel button started; the board sets these through one-cycle event inputs. Two bits mark a cold or warm reset that software started. All other bits read as zero.

The word sits in the low half of an 8-byte slot on a simple register port. Writes are first cut down to the flag field. The power-up flag and the two button flags are cleared by writing one. The two software flags can only be set by writing one. A write that sets a software flag also sends a one-cycle request to the system reset sequencer.

A saturating counter separates the very first system reset from later ones. The first reset after power-up loads the word with only the power-up flag. Later resets leave the recorded causes unchanged, so software can read them after the restart. A software cold-reset write clears the counter, so the reset that follows it counts as a first reset again. Two reset inputs are used. `por_n` clears everything, counter included. `rst_n` is the system reset that the counter tracks.

Top module: `rst_status_ctrl`

## Requirements
- R1: While `por_n` is low the status word and `sys_rst_req` are cleared, and the reset counter returns to zero.
- R2: The first cycle of a `rst_n` assertion while the counter is zero loads the status word with 0x80000000 (power-up flag, bit 31, only).
- R3: A `rst_n` assertion while the counter is non-zero leaves the status word unchanged. The counter counts each assertion once and saturates at its maximum.
- R4: Write data is masked to bits 31:27 before use, and bits 26:0 of `acc_rdata` always read zero.
- R5: In a low-word write, a one in bit 31 (power-up), bit 28 (button cold) or bit 27 (button warm) clears that flag. A zero leaves the flag unchanged.
- R6: In a low-word write, a one in bit 30 (software cold) or bit 29 (software warm) sets that flag. A zero leaves it unchanged, so no write can clear these bits.
- R7: A low-word write with bit 30 set gives `sys_rst_req` high for exactly the one cycle after the write edge. It also clears the counter, so the next `rst_n` assertion loads 0x80000000.
- R8: A low-word write with bit 29 set and bit 30 clear gives the same one-cycle request but keeps the counter, so the next reset keeps the recorded causes.
- R9: An access with `acc_lo_word` low (address bit 2 clear, the high word) reads zero and its writes change nothing.
- R10: A `btn_cold` or `btn_warm` event sets bit 28 or bit 27. If a write clears the same bit in the same cycle, the event wins.
- R11: While `rst_n` is low, register writes and button events are ignored and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, synchronous, active low; clears all state |
| rst_n | input | 1 | System reset, synchronous, active low; counted as a reset event |
| acc_en | input | 1 | Register access valid this cycle |
| acc_wr | input | 1 | Access is a write |
| acc_lo_word | input | 1 | Address bit 2: 1 selects the status word, 0 the unused high word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from the current status |
| btn_cold | input | 1 | One-cycle event: button cold reset observed |
| btn_warm | input | 1 | One-cycle event: button warm reset observed |
| sys_rst_req | output | 1 | One-cycle request to the system reset sequencer |

## Verification
A hardware button event and a software write-one-to-clear of the same flag can arrive in the same cycle. The same is true of a system reset and a register write. The bench forces both collisions in directed steps: a `btn_warm` pulse together with a write of 0x08000000, and a soft cold-reset write with `rst_n` low. It then expects the flag to stay set in the first case, and no change and no request in the second. The random phase mixes writes, button events and resets independently, so these collisions recur, and the bench model settles each one with the same priorities.

// File: rtl/rsc_pkg.sv
// Package: shared constants for the reset cause and control register.
// Assumes a 32-bit data word with the flag field in bits 31:27.
package rsc_pkg;
    localparam int REG_W       = 32;
    localparam int FLAG_HI     = 31;
    localparam int FLAG_LO     = 27;
    localparam int BIT_PWRUP   = 31;
    localparam int BIT_SWCOLD  = 30;
    localparam int BIT_SWWARM  = 29;
    localparam int BIT_BTNCOLD = 28;
    localparam int BIT_BTNWARM = 27;

    localparam logic [REG_W-1:0] FLAG_FIELD = 32'hF800_0000;
    localparam logic [REG_W-1:0] CLR_FIELD  = 32'h9800_0000;
    localparam logic [REG_W-1:0] SET_FIELD  = 32'h6000_0000;
    localparam logic [REG_W-1:0] FIRST_LOAD = 32'h8000_0000;
endpackage

// File: rtl/rsc_write_decode.sv
// Module: rsc_write_decode
// Turns an accepted write into per-bit clear and set vectors and the
// reset request kind. Assumes wr_fire is already gated by address and reset.
module rsc_write_decode
    import rsc_pkg::*;
(
    input  logic             wr_fire,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] clr_bits,
    output logic [REG_W-1:0] set_bits,
    output logic             req_cold,
    output logic             req_warm
);
    logic [REG_W-1:0] masked;

    // Cut the write to the flag field and split it by bit kind.
    always_comb begin
        masked   = wr_fire ? (wdata & FLAG_FIELD) : '0;
        clr_bits = masked & CLR_FIELD;
        set_bits = masked & SET_FIELD;
        req_cold = masked[BIT_SWCOLD];
        req_warm = masked[BIT_SWWARM] & ~masked[BIT_SWCOLD];
    end
endmodule

// File: rtl/rsc_reset_tracker.sv
// Module: rsc_reset_tracker
// Counts system reset assertions (once per assertion, saturating) and
// flags the first cycle of an assertion that finds the counter at zero.
// Assumes cnt_clear is only raised while rst_n is high.
module rsc_reset_tracker #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic cnt_clear,
    output logic reset_evt,
    output logic load_first
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             rst_prev_q;

    // Reset event is the first cycle of an rst_n assertion.
    always_comb begin
        reset_evt  = ~rst_n & rst_prev_q;
        load_first = reset_evt & (cnt_q == '0);
    end

    // Track previous rst_n level and the saturating reset count.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q      <= '0;
            rst_prev_q <= 1'b1;
        end else begin
            rst_prev_q <= rst_n;
            if (reset_evt) begin
                if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else if (rst_n && cnt_clear) begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/rsc_status_reg.sv
// Module: rsc_status_reg
// Holds the five flag bits, one generated cell per bit, and the
// registered reset request. Bits below the flag field are constant zero.
// Assumes clear, set and event vectors are zero while rst_n is low.
module rsc_status_reg
    import rsc_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             load_first,
    input  logic [REG_W-1:0] clr_bits,
    input  logic [REG_W-1:0] set_bits,
    input  logic [REG_W-1:0] hw_bits,
    input  logic             req_in,
    output logic [REG_W-1:0] status,
    output logic             sys_rst_req
);
    logic [FLAG_HI:FLAG_LO] flag_q;

    for (genvar i = FLAG_LO; i <= FLAG_HI; i++) begin : g_flag
        localparam logic LOAD_VAL = FIRST_LOAD[i];
        logic bit_q;

        // One flag cell: first-reset load, hold in reset, else clear/set.
        always_ff @(posedge clk) begin
            if (!por_n) begin
                bit_q <= 1'b0;
            end else if (!rst_n) begin
                if (load_first) bit_q <= LOAD_VAL;
            end else begin
                bit_q <= (bit_q & ~clr_bits[i]) | set_bits[i] | hw_bits[i];
            end
        end

        assign flag_q[i] = bit_q;
    end

    assign status = {flag_q, {FLAG_LO{1'b0}}};

    // Register the reset request so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!por_n) sys_rst_req <= 1'b0;
        else        sys_rst_req <= rst_n & req_in;
    end
endmodule

// File: rtl/rst_status_ctrl.sv
// Module: rst_status_ctrl (top)
// Reset cause and soft-reset control register on a simple register port.
// Assumes one access per cycle; reads are combinational from the status.
module rst_status_ctrl
    import rsc_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic             acc_lo_word,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] acc_rdata,
    input  logic             btn_cold,
    input  logic             btn_warm,
    output logic             sys_rst_req
);
    logic             wr_fire;
    logic [REG_W-1:0] clr_bits;
    logic [REG_W-1:0] set_bits;
    logic [REG_W-1:0] hw_bits;
    logic             req_cold;
    logic             req_warm;
    logic             reset_evt;
    logic             load_first;
    logic [REG_W-1:0] status_q;

    // Qualify writes and button events; both are ignored in reset.
    always_comb begin
        wr_fire              = acc_en & acc_wr & acc_lo_word & rst_n;
        hw_bits              = '0;
        hw_bits[BIT_BTNCOLD] = btn_cold & rst_n;
        hw_bits[BIT_BTNWARM] = btn_warm & rst_n;
    end

    rsc_write_decode u_dec (
        .wr_fire  (wr_fire),
        .wdata    (acc_wdata),
        .clr_bits (clr_bits),
        .set_bits (set_bits),
        .req_cold (req_cold),
        .req_warm (req_warm)
    );

    rsc_reset_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .cnt_clear  (req_cold),
        .reset_evt  (reset_evt),
        .load_first (load_first)
    );

    rsc_status_reg u_stat (
        .clk         (clk),
        .por_n       (por_n),
        .rst_n       (rst_n),
        .load_first  (load_first),
        .clr_bits    (clr_bits),
        .set_bits    (set_bits),
        .hw_bits     (hw_bits),
        .req_in      (req_cold | req_warm),
        .status      (status_q),
        .sys_rst_req (sys_rst_req)
    );

    // Read mux: only the low word of the slot returns the status.
    assign acc_rdata = (acc_en && acc_lo_word) ? status_q : '0;
endmodule

// File: rtl/rsc_checker.sv
// Module: rsc_checker
// Concurrent checks on the reset cause register, bound into the top.
module rsc_checker (
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_lo_word,
    input logic [31:0] acc_wdata,
    input logic [31:0] acc_rdata,
    input logic        wr_fire,
    input logic        load_first,
    input logic [31:0] status_q,
    input logic        sys_rst_req
);
    // R1: power-up reset clears status and request.
    a_r1_por_clears: assert property (@(posedge clk)
        !por_n |=> (status_q == 32'h0) && !sys_rst_req);

    // R2: first reset loads only the power-up flag.
    a_r2_first_load: assert property (@(posedge clk) disable iff (!por_n)
        load_first |=> status_q == 32'h8000_0000);

    // R3: later resets keep the recorded causes.
    a_r3_keep_cause: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !load_first) |=> $stable(status_q));

    // R4: low bits always read zero.
    a_r4_low_zero: assert property (@(posedge clk) disable iff (!por_n)
        acc_rdata[26:0] == 27'h0);

    // R7: a request only follows an accepted soft-reset write.
    a_r7_req_cause: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst_req |-> $past(wr_fire && (acc_wdata[30] || acc_wdata[29])));

    // R9: high word reads zero.
    a_r9_hi_zero: assert property (@(posedge clk) disable iff (!por_n)
        (acc_en && !acc_lo_word) |-> acc_rdata == 32'h0);
endmodule

bind rst_status_ctrl rsc_checker u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .rst_n       (rst_n),
    .acc_en      (acc_en),
    .acc_lo_word (acc_lo_word),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .wr_fire     (wr_fire),
    .load_first  (load_first),
    .status_q    (status_q),
    .sys_rst_req (sys_rst_req)
);

// File: tb/sim_rst_status_ctrl.sv
// Bench for rst_status_ctrl: directed corner cases then seeded random steps.
module sim_rst_status_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_MAX    = 15;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b1;
    logic        acc_en = 1'b0, acc_wr = 1'b0, acc_lo_word = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        btn_cold = 1'b0, btn_warm = 1'b0;
    logic        sys_rst_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // model state
    logic [31:0] m_stat = '0;
    int          m_cnt  = 0;
    bit          m_prev = 1'b1;
    bit          m_req  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_status_ctrl u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .acc_en(acc_en),
        .acc_wr(acc_wr), .acc_lo_word(acc_lo_word), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .btn_cold(btn_cold), .btn_warm(btn_warm),
        .sys_rst_req(sys_rst_req)
    );

    // Model of one clock edge, written from the requirements.
    function automatic void model_edge(bit p, bit r, bit en, bit wr, bit lo,
                                       logic [31:0] wd, bit bc, bit bw);
        logic [31:0] v;
        if (!p) begin
            m_stat = '0; m_cnt = 0; m_prev = 1'b1; m_req = 1'b0;
        end else if (!r) begin
            if (m_prev) begin
                if (m_cnt == 0) m_stat = 32'h8000_0000;
                if (m_cnt < CNT_MAX) m_cnt++;
            end
            m_prev = 1'b0; m_req = 1'b0;
        end else begin
            m_prev = 1'b1; m_req = 1'b0;
            if (en && wr && lo) begin
                v = wd & 32'hF800_0000;
                m_stat = (m_stat & ~(v & 32'h9800_0000)) | (v & 32'h6000_0000);
                m_req  = v[30] | v[29];
                if (v[30]) m_cnt = 0;
            end
            if (bc) m_stat[28] = 1'b1;
            if (bw) m_stat[27] = 1'b1;
        end
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then read back status and request.
    task automatic step(bit p, bit r, bit en, bit wr, bit lo, logic [31:0] wd,
                        bit bc, bit bw, string tag);
        @(negedge clk);
        por_n = p; rst_n = r; acc_en = en; acc_wr = wr; acc_lo_word = lo;
        acc_wdata = wd; btn_cold = bc; btn_warm = bw;
        model_edge(p, r, en, wr, lo, wd, bc, bw);
        @(posedge clk);
        #1;
        acc_en = 1'b1; acc_wr = 1'b0; acc_lo_word = 1'b1;
        btn_cold = 1'b0; btn_warm = 1'b0;
        #1;
        check(tag, "status", acc_rdata, m_stat);
        check("R7", "request", {31'h0, sys_rst_req}, {31'h0, m_req});
    endtask

    task automatic idle(string tag);
        step(1, 1, 0, 0, 0, '0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        // R1: power-up reset state
        step(0, 1, 0, 0, 0, '0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, '0, 0, 0, "R1");
        idle("R1");
        // R2: first system reset, held two cycles
        step(1, 0, 0, 0, 0, '0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, '0, 0, 0, "R2");
        idle("R2");
        // R4 R5 R6 R7: all-ones write
        step(1, 1, 1, 1, 1, 32'hFFFF_FFFF, 0, 0, "R4");
        idle("R7");
        // R9: high word write ignored, high word reads zero
        step(1, 1, 1, 1, 0, 32'h9800_0000, 0, 0, "R9");
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_lo_word = 1'b0;
        #1;
        check("R9", "high word read", acc_rdata, 32'h0);
        // R10: button events, and event beats clear in same cycle
        step(1, 1, 0, 0, 0, '0, 1, 0, "R10");
        step(1, 1, 1, 1, 1, 32'h0800_0000, 0, 1, "R10");
        check("R10", "warm flag kept", acc_rdata, 32'h7800_0000);
        // R5: clear both button flags
        step(1, 1, 1, 1, 1, 32'h1800_0000, 0, 0, "R5");
        check("R5", "button flags cleared", acc_rdata, 32'h6000_0000);
        // R7: counter cleared by cold write, so next reset loads first value
        step(1, 0, 0, 0, 0, '0, 0, 0, "R7");
        idle("R7");
        check("R7", "reload after soft cold", acc_rdata, 32'h8000_0000);
        // R8: warm write keeps counter, next reset keeps causes
        step(1, 1, 1, 1, 1, 32'h2000_0000, 0, 0, "R8");
        idle("R8");
        step(1, 0, 0, 0, 0, '0, 0, 0, "R8");
        idle("R3");
        check("R8", "causes kept over reset", acc_rdata, 32'hA000_0000);
        // R6: write zero changes nothing
        step(1, 1, 1, 1, 1, 32'h0000_0000, 0, 0, "R6");
        // R11: write and button during reset ignored, no request
        step(1, 0, 1, 1, 1, 32'h5800_0000, 1, 1, "R11");
        idle("R11");
        check("R11", "ignored in reset", acc_rdata, 32'hA000_0000);
        // random phase
        for (int n = 0; n < 3000; n++) begin
            bit p, r, en, wr, lo, bc, bw;
            logic [31:0] wd;
            string tag;
            p  = ($urandom_range(0, 99) != 0);
            r  = ($urandom_range(0, 11) != 0);
            en = $urandom_range(0, 1);
            wr = $urandom_range(0, 1);
            lo = ($urandom_range(0, 3) != 0);
            wd = $urandom();
            if ($urandom_range(0, 3) != 0) wd[30] = 1'b0;
            bc = ($urandom_range(0, 7) == 0);
            bw = ($urandom_range(0, 7) == 0);
            if (!p)                     tag = "R1";
            else if (!r)                tag = "R3";
            else if (en && wr && lo)    tag = "R5";
            else if (en && wr)          tag = "R9";
            else                        tag = "R10";
            step(p, r, en, wr, lo, wd, bc, bw, tag);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule